// File: doc/BRIEF.md
# Buffered 16-bit Up-Counter with Trigger Clear

This block is a 16-bit up-counter that a host reaches over a narrow 8-bit register bus. It has four byte-wide locations: the counter's low byte, the counter's high byte, a control byte and a status byte. An input tick advances the counter through a programmable prescaler. When the counter wraps it latches an overflow flag, which drives an interrupt output once an enable bit allows it. A separate trigger input clears the counter. When an outside compare unit drives that input, the compare value becomes the counter's period.

In the wide-access mode, the high-byte location stops reaching the live counter and reaches a shadow byte instead. A read of the low byte copies the live high byte into the shadow at that moment, so a later read of the high-byte location returns a value that matches the earlier low-byte read. A host write to the high-byte location fills only the shadow. The next write to the low byte then loads all sixteen bits in one cycle. This gives reads and writes that never tear across a carry between the two bytes.

Byte map, by address: 0 is the counter's low byte and 1 is the counter's high byte (or the shadow in wide mode). 2 is control, with bit 0 run, bits 2:1 prescale select, bit 3 wide mode and bit 4 interrupt enable. 3 is status, with bit 0 the overflow flag. Read data is combinational from the address. A read side effect happens on the clock edge where `rd_en` is high.

Top module: `tmr16_buf`

## Requirements
- R1: After reset the counter is 0x0000, the control byte is 0x00, the overflow flag is 0 and `irq` is 0.
- R2: Control bits 2:1 select a prescale ratio of 1, 2, 4 or 8 (encoded 0, 1, 2, 3). While run (control bit 0) is 1, the counter advances by one for each ratio's worth of cycles that have `tick` high.
- R3: While run is 0, `tick` has no effect on the counter.
- R4: An increment from 0xFFFF gives 0x0000 and sets the overflow flag (status bit 0). The flag stays set until software clears it.
- R5: `irq` is high exactly when the overflow flag is 1 and interrupt enable (control bit 4) is 1.
- R6: A write to status with bit 0 equal to 0 clears the flag, and a write with bit 0 equal to 1 leaves it unchanged. If a wrap happens in the same cycle as a clearing write, the flag ends up set.
- R7: A cycle with `trig` high clears the counter to 0x0000, even when an increment from 0xFFFF was due in that cycle, and it never sets the overflow flag.
- R8: A host write to the counter in the same cycle as `trig` takes effect and the trigger is dropped.
- R9: With wide mode (control bit 3) set, a read of address 0 copies the live high byte into the shadow. A read of address 1 then returns the shadow and not the live high byte.
- R10: With wide mode set, a write to address 1 changes only the shadow. A write to address 0 loads the low byte from the write data and the high byte from the shadow, both in that same cycle.
- R11: With wide mode clear, address 1 reads and writes the live high byte directly.
- R12: A write to address 0 restarts the prescaler's count, and a write to address 1 leaves the prescaler's count as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count pulse, sampled each cycle |
| trig | input | 1 | Special-event counter clear |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (for the read side effect) |
| addr | input | 2 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | Overflow interrupt |

## Verification
The checker assumes that the host asserts at most one of `wr_en` and `rd_en` in a cycle, and that every strobe and trigger lasts exactly one clock. It also assumes that a counter write and a wide-mode shadow write never share a cycle, since they go to distinct addresses. The stimulus drives every input at the falling edge through one bus task, which raises each strobe for a single cycle and lowers all of them afterwards. Cases where an increment, a trigger, a clear and a host write collide are set up on purpose, only at the precise cycles named in the requirements.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
    localparam int BUS_W = 8;
    localparam int PS_W  = 2;

    localparam logic [1:0] A_LO   = 2'd0;
    localparam logic [1:0] A_HI   = 2'd1;
    localparam logic [1:0] A_CTRL = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    typedef struct packed {
        logic            ie;
        logic            wide;
        logic [PS_W-1:0] ps_sel;
        logic            run;
    } ctrl_t;
endpackage

// File: rtl/tmr16_prescale.sv
module tmr16_prescale #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             step
);
    localparam int PRE_W = (1 << SEL_W) - 1;

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] limit;

    always_comb begin
        limit = PRE_W'((1 << sel) - 1);
        step  = run && tick && (pre_q == limit);
        pre_d = pre_q;
        if (clr) begin
            pre_d = '0;
        end else if (run && tick) begin
            pre_d = step ? '0 : pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/tmr16_count.sv
module tmr16_count #(
    parameter int BW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [1:0]      addr,
    input  logic [BW-1:0]   wdata,
    input  logic            trig,
    input  logic            step,
    input  logic            wide,
    output logic [2*BW-1:0] cnt,
    output logic [BW-1:0]   shadow,
    output logic            flag
);
    import tmr16_pkg::*;
    localparam int CW = 2 * BW;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [BW-1:0] shadow;
        logic          flag;
    } state_t;

    state_t st_d, st_q;
    logic lo_wr, hi_wr, cnt_wr, clr_wr, wrap;

    always_comb begin
        st_d   = st_q;
        lo_wr  = wr_en && (addr == A_LO);
        hi_wr  = wr_en && (addr == A_HI);
        clr_wr = wr_en && (addr == A_STAT) && !wdata[0];
        cnt_wr = lo_wr || (hi_wr && !wide);
        wrap   = 1'b0;

        if (cnt_wr) begin
            if (lo_wr) begin
                st_d.cnt[BW-1:0] = wdata;
                if (wide) st_d.cnt[CW-1:BW] = st_q.shadow;
            end else begin
                st_d.cnt[CW-1:BW] = wdata;
            end
        end else if (trig) begin
            st_d.cnt = '0;
        end else if (step) begin
            st_d.cnt = st_q.cnt + 1'b1;
            wrap     = (st_q.cnt == '1);
        end

        if (wide && hi_wr) begin
            st_d.shadow = wdata;
        end else if (wide && rd_en && (addr == A_LO)) begin
            st_d.shadow = st_q.cnt[CW-1:BW];
        end

        if (clr_wr) st_d.flag = 1'b0;
        if (wrap)   st_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt    = st_q.cnt;
    assign shadow = st_q.shadow;
    assign flag   = st_q.flag;
endmodule

// File: rtl/tmr16_buf.sv
module tmr16_buf (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       trig,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq
);
    import tmr16_pkg::*;
    localparam int CW    = 2 * BUS_W;
    localparam int CTL_W = $bits(ctrl_t);

    ctrl_t ctrl_d, ctrl_q;
    logic [CW-1:0]    cnt;
    logic [BUS_W-1:0] shadow;
    logic             flag, step, pre_clr;

    always_comb begin
        ctrl_d  = ctrl_q;
        if (wr_en && (addr == A_CTRL)) ctrl_d = ctrl_t'(wdata[CTL_W-1:0]);
        pre_clr = wr_en && (addr == A_LO);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    tmr16_prescale #(.SEL_W(PS_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (ctrl_q.run),
        .tick (tick),
        .clr  (pre_clr),
        .sel  (ctrl_q.ps_sel),
        .step (step)
    );

    tmr16_count #(.BW(BUS_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .trig  (trig),
        .step  (step),
        .wide  (ctrl_q.wide),
        .cnt   (cnt),
        .shadow(shadow),
        .flag  (flag)
    );

    always_comb begin
        unique case (addr)
            A_LO:    rdata = cnt[BUS_W-1:0];
            A_HI:    rdata = ctrl_q.wide ? shadow : cnt[CW-1:BUS_W];
            A_CTRL:  rdata = BUS_W'(ctrl_q);
            default: rdata = BUS_W'(flag);
        endcase
    end

    assign irq = flag && ctrl_q.ie;
endmodule

// File: rtl/tmr16_buf_chk.sv
module tmr16_buf_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        trig,
    input logic        wr_en,
    input logic [1:0]  addr,
    input logic [7:0]  wdata,
    input logic        irq,
    input logic [15:0] cnt,
    input logic        flag,
    input logic        step,
    input logic        run,
    input logic        wide,
    input logic        ie
);
    logic cnt_wr;
    assign cnt_wr = wr_en && ((addr == 2'd0) || ((addr == 2'd1) && !wide));

    // R7
    trig_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !cnt_wr) |=> (cnt == 16'h0000));

    // R7
    trig_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !cnt_wr && !flag) |=> !flag);

    // R4
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (cnt == 16'hFFFF) && !trig && !cnt_wr) |=> (flag && (cnt == 16'h0000)));

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(wr_en && (addr == 2'd3) && !wdata[0])) |=> flag);

    // R3
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !trig && !wr_en) |=> $stable(cnt));

    // R10
    wide_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wide && wr_en && (addr == 2'd1) && !trig && !step) |=> $stable(cnt));

    // R5
    irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ie && flag) |-> !irq);
endmodule

bind tmr16_buf tmr16_buf_chk u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .trig (trig),
    .wr_en(wr_en),
    .addr (addr),
    .wdata(wdata),
    .irq  (irq),
    .cnt  (cnt),
    .flag (flag),
    .step (step),
    .run  (ctrl_q.run),
    .wide (ctrl_q.wide),
    .ie   (ctrl_q.ie)
);

// File: tb/sim_tmr16_buf.sv
`timescale 1ns/1ps
module sim_tmr16_buf;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, trig = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq;
    logic [7:0] rd_last;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    tmr16_buf u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .trig(trig),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle of stimulus, entered and left at a falling edge
    task automatic cyc(input logic w, input logic r, input logic [1:0] a,
                       input logic [7:0] d, input logic tk, input logic tg);
        wr_en = w; rd_en = r; addr = a; wdata = d; tick = tk; trig = tg;
        #1 rd_last = rdata;
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; rd_en = 0; tick = 0; trig = 0; addr = 2'd0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cyc(1, 0, a, d, 0, 0);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        cyc(0, 1, a, 8'h00, 0, 0);
        v = rd_last;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 2'd0, 8'h00, 1, 0);
    endtask

    task automatic set_cnt(input logic [7:0] hi, input logic [7:0] lo);
        wr(2'd1, hi);
        wr(2'd0, lo);
    endtask

    task automatic chk_cnt(input string req, input logic [15:0] exp);
        logic [7:0] h, l;
        rd(2'd0, l);
        rd(2'd1, h);
        check(req, {h, l}, exp);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk_cnt("R1 count", 16'h0000);
        rd(2'd2, v); check("R1 ctrl", v, 16'h00);
        rd(2'd3, v); check("R1 flag", v, 16'h00);
        check("R1 irq", irq, 1'b0);
    endtask

    task automatic t_prescale();
        ticks(3);
        chk_cnt("R3 run off", 16'h0000);
        wr(2'd2, 8'h01);
        ticks(5);
        chk_cnt("R2 ratio1", 16'h0005);
        wr(2'd2, 8'h05);
        set_cnt(8'h00, 8'h00);
        ticks(12);
        chk_cnt("R2 ratio4", 16'h0003);
        wr(2'd2, 8'h07);
        set_cnt(8'h00, 8'h00);
        ticks(15);
        chk_cnt("R2 ratio8", 16'h0001);
    endtask

    task automatic t_presc_clear();
        wr(2'd2, 8'h05);
        set_cnt(8'h00, 8'h00);
        ticks(2);
        wr(2'd1, 8'h00);
        ticks(2);
        chk_cnt("R12 hi write keeps prescaler", 16'h0001);
        set_cnt(8'h00, 8'h00);
        ticks(2);
        wr(2'd0, 8'h00);
        ticks(2);
        chk_cnt("R12 lo write clears prescaler", 16'h0000);
    endtask

    task automatic t_wrap();
        logic [7:0] v;
        wr(2'd2, 8'h01);
        set_cnt(8'hFF, 8'hFE);
        ticks(1);
        rd(2'd3, v); check("R4 no early flag", v, 16'h00);
        ticks(1);
        chk_cnt("R4 wrap value", 16'h0000);
        rd(2'd3, v); check("R4 flag set", v, 16'h01);
        ticks(3);
        rd(2'd3, v); check("R4 flag sticky", v, 16'h01);
        check("R5 irq masked", irq, 1'b0);
        wr(2'd2, 8'h11);
        check("R5 irq enabled", irq, 1'b1);
        wr(2'd3, 8'h01);
        rd(2'd3, v); check("R6 write one keeps", v, 16'h01);
        wr(2'd3, 8'h00);
        rd(2'd3, v); check("R6 cleared", v, 16'h00);
        check("R5 irq drops", irq, 1'b0);
        set_cnt(8'hFF, 8'hFF);
        cyc(1, 0, 2'd3, 8'h00, 1, 0);
        rd(2'd3, v); check("R6 set beats clear", v, 16'h01);
        check("R5 irq on", irq, 1'b1);
        wr(2'd3, 8'h00);
    endtask

    task automatic t_trig();
        logic [7:0] v;
        wr(2'd2, 8'h01);
        set_cnt(8'h45, 8'h67);
        cyc(0, 0, 2'd0, 8'h00, 0, 1);
        chk_cnt("R7 trig clears", 16'h0000);
        set_cnt(8'hFF, 8'hFF);
        cyc(0, 0, 2'd0, 8'h00, 1, 1);
        chk_cnt("R7 trig over wrap", 16'h0000);
        rd(2'd3, v); check("R7 no flag", v, 16'h00);
        wr(2'd2, 8'h00);
        set_cnt(8'h12, 8'h34);
        cyc(1, 0, 2'd0, 8'h33, 0, 1);
        chk_cnt("R8 write beats trig", 16'h1233);
    endtask

    task automatic t_wide();
        logic [7:0] v;
        wr(2'd2, 8'h00);
        set_cnt(8'h12, 8'h34);
        wr(2'd2, 8'h08);
        rd(2'd0, v); check("R9 lo read", v, 16'h34);
        cyc(0, 0, 2'd0, 8'h00, 0, 1);
        rd(2'd1, v); check("R9 shadow read", v, 16'h12);
        wr(2'd2, 8'h00);
        rd(2'd1, v); check("R11 live hi read", v, 16'h00);
        wr(2'd1, 8'h56);
        chk_cnt("R11 direct hi write", 16'h5600);
        wr(2'd2, 8'h08);
        wr(2'd1, 8'hAB);
        wr(2'd2, 8'h00);
        chk_cnt("R10 hi write to shadow only", 16'h5600);
        wr(2'd2, 8'h08);
        wr(2'd0, 8'hCD);
        wr(2'd2, 8'h00);
        chk_cnt("R10 lo write loads both", 16'hABCD);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prescale();
        t_presc_clear();
        t_wrap();
        t_trig();
        t_wide();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule